// File: doc/BRIEF.md
# Virtual Address Segment Mapper

This block is the front end of address translation. For each accepted request it decides which of three paths a 32-bit virtual address takes. When translation is switched off, the address passes through untouched with every permission granted. When the address lies in a segment marked for direct mapping and the access comes from kernel mode, the top four address bits are replaced by a physical segment number read from a pair of packed base registers. The paged table lookup is skipped in that case. In every other case the request goes to a separate page-table lookup unit, and that unit's answer is returned.

The block also reports which translation unit serves the request. Instruction fetches go to the instruction side; loads and stores go to the data side. The selector output shows that route only while a lookup is outstanding, and otherwise follows an idle value supplied from outside. Results come from registers and carry a one-cycle valid strobe. While a paged lookup is pending the block accepts no new request.

Top module: `vaddr_segment_mapper`

## Requirements
- R1: When `cfgEnable` (bits 3:2 of the global configuration word) is 2'b00, an accepted request returns `rspPhys` equal to `reqAddr`, `rspPerm` = 3'b111 and `rspMiss` = 0. Permission bits are: bit 0 read, bit 1 write, bit 2 execute.
- R2: Translation is on when either bit of `cfgEnable` is set. The values 2'b01, 2'b10 and 2'b11 all behave the same.
- R3: With translation on, a request is direct-mapped only when `cfgSegMask[reqAddr[31:28]]` is 1 and `reqUser` is 0. A user-mode request to such a segment goes to the paged lookup.
- R4: Segments 0 to 7 take their physical segment from `cfgBaseLo`, and segments 8 to 15 from `cfgBaseHi`. The value is the nibble at bits 4*(seg mod 8)+3 down to 4*(seg mod 8).
- R5: A direct-mapped result has `rspPhys` = {selected nibble, `reqAddr[27:0]`}, `rspPerm` = 3'b111 and `rspMiss` = 0.
- R6: A passthrough or direct request accepted at clock edge N drives `rspValid` high for exactly the cycle after edge N, with the result on the result ports. Back-to-back requests are accepted on consecutive edges.
- R7: A paged request accepted at edge N drives `tlbReqValid` for one cycle after N, with `tlbReqAddr`, `tlbReqKind` and `tlbReqUser` taken from the request. `reqReady` stays low until an edge where `tlbRspValid` is high. The cycle after that edge carries `rspValid` together with the lookup unit's phys, perm and miss values.
- R8: Access kind encoding is 2'b00 read, 2'b01 write, 2'b10 execute, and 2'b11 counts as a read. While a paged lookup is pending, `mmuSel` is 2'd1 for execute and 2'd2 otherwise, and `tlbReqInstr` is 1 only for execute. At all other times `mmuSel` equals `selIdle`.
- R9: `reqValid` while `reqReady` is low is ignored. It produces no result and no lookup request.
- R10: Configuration inputs are sampled only at the accepting edge. Changing them while a lookup is pending does not alter that request's result.
- R11: After reset `rspValid` and `tlbReqValid` are 0, `reqReady` is 1 and `mmuSel` equals `selIdle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 32 | Virtual address |
| reqKind | input | 2 | Access kind (R8 encoding) |
| reqUser | input | 1 | 1 = user mode |
| cfgEnable | input | 2 | Translation enable field |
| cfgSegMask | input | 16 | Per-segment direct-map enable |
| cfgBaseLo | input | 32 | Packed physical segments 0..7 |
| cfgBaseHi | input | 32 | Packed physical segments 8..15 |
| selIdle | input | 2 | Selector value when no lookup is pending |
| mmuSel | output | 2 | Current translation-unit selector |
| tlbReqValid | output | 1 | Lookup request strobe |
| tlbReqAddr | output | 32 | Lookup virtual address |
| tlbReqKind | output | 2 | Lookup access kind |
| tlbReqUser | output | 1 | Lookup user flag |
| tlbReqInstr | output | 1 | Lookup targets the instruction side |
| tlbRspValid | input | 1 | Lookup answer strobe |
| tlbRspPhys | input | 32 | Lookup physical address |
| tlbRspPerm | input | 3 | Lookup permissions |
| tlbRspMiss | input | 1 | Lookup miss flag |
| rspValid | output | 1 | Result strobe |
| rspPhys | output | 32 | Result physical address |
| rspPerm | output | 3 | Result permissions |
| rspMiss | output | 1 | Result miss flag |

## Verification
Passthrough and direct results are due one cycle after the accepting edge. A lookup request is due one cycle after its accepting edge. A paged result is due one cycle after the edge where the lookup answer is seen. The bench holds a behavioural model that is updated on the same rising edge as the design. All outputs are compared one nanosecond after every edge, and inputs change only on falling edges, so each comparison falls inside the cycle where the value is due. The responder's latency varies from zero to several cycles, which moves the paged result while the model follows it edge by edge.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_EXEC  = 2'b10,
    KIND_RSVD  = 2'b11
  } accessKind_t;

  localparam logic [1:0] SEL_INSTR = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic loadPass;    // passthrough result into output regs
    logic loadDirect;  // segment remap result into output regs
    logic capture;     // latch request for paged lookup
    logic loadTlb;     // lookup answer into output regs
  } ctrlStrobe_t;

endpackage

// File: rtl/vsm_nibble_pick.sv
module vsm_nibble_pick #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0]                 seg,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  baseLo,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  baseHi,
  output logic [SEG_W-1:0]                 physSeg
);
  localparam int PER_REG = 1 << (SEG_W - 1);
  localparam int IDX_W   = SEG_W - 1;

  logic [SEG_W-1:0] loNib [PER_REG];
  logic [SEG_W-1:0] hiNib [PER_REG];
  logic [IDX_W-1:0] slot;

  for (genvar g = 0; g < PER_REG; g++) begin : g_split
    assign loNib[g] = baseLo[g*SEG_W +: SEG_W];
    assign hiNib[g] = baseHi[g*SEG_W +: SEG_W];
  end

  assign slot    = seg[IDX_W-1:0];
  assign physSeg = seg[SEG_W-1] ? hiNib[slot] : loNib[slot];

endmodule

// File: rtl/vsm_datapath.sv
module vsm_datapath
  import vsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int PERM_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  ctrlStrobe_t                      strobe,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [1:0]                       reqKind,
  input  logic                             reqUser,
  input  logic [1:0]                       cfgEnable,
  input  logic [(1<<SEG_W)-1:0]            cfgSegMask,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  cfgBaseLo,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  cfgBaseHi,
  input  logic [ADDR_W-1:0]                tlbRspPhys,
  input  logic [PERM_W-1:0]                tlbRspPerm,
  input  logic                             tlbRspMiss,
  output logic                             pathPass,
  output logic                             pathDirect,
  output logic [ADDR_W-1:0]                tlbReqAddr,
  output logic [1:0]                       tlbReqKind,
  output logic                             tlbReqUser,
  output logic                             tlbReqInstr,
  output logic [1:0]                       routeSel,
  output logic [ADDR_W-1:0]                rspPhys,
  output logic [PERM_W-1:0]                rspPerm,
  output logic                             rspMiss
);
  localparam int OFF_W = ADDR_W - SEG_W;
  localparam logic [PERM_W-1:0] PERM_ALL = {PERM_W{1'b1}};

  logic [SEG_W-1:0]  reqSeg;
  logic [SEG_W-1:0]  physSeg;
  logic [ADDR_W-1:0] directPhys;
  logic [ADDR_W-1:0] pendAddr;
  logic [1:0]        pendKind;
  logic              pendUser;

  assign reqSeg     = reqAddr[ADDR_W-1 -: SEG_W];
  assign pathPass   = ~|cfgEnable;
  assign pathDirect = !reqUser && cfgSegMask[reqSeg];

  vsm_nibble_pick #(.SEG_W(SEG_W)) uPick (
    .seg    (reqSeg),
    .baseLo (cfgBaseLo),
    .baseHi (cfgBaseHi),
    .physSeg(physSeg)
  );

  assign directPhys = {physSeg, reqAddr[OFF_W-1:0]};

  // Pending request for the paged path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendAddr <= '0;
      pendKind <= KIND_READ;
      pendUser <= 1'b0;
    end else if (strobe.capture) begin
      pendAddr <= reqAddr;
      pendKind <= reqKind;
      pendUser <= reqUser;
    end
  end

  assign tlbReqAddr  = pendAddr;
  assign tlbReqKind  = pendKind;
  assign tlbReqUser  = pendUser;
  assign tlbReqInstr = (pendKind == KIND_EXEC);
  assign routeSel    = tlbReqInstr ? SEL_INSTR : SEL_DATA;

  // Result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspPhys <= '0;
      rspPerm <= '0;
      rspMiss <= 1'b0;
    end else begin
      unique case (1'b1)
        strobe.loadPass: begin
          rspPhys <= reqAddr;
          rspPerm <= PERM_ALL;
          rspMiss <= 1'b0;
        end
        strobe.loadDirect: begin
          rspPhys <= directPhys;
          rspPerm <= PERM_ALL;
          rspMiss <= 1'b0;
        end
        strobe.loadTlb: begin
          rspPhys <= tlbRspPhys;
          rspPerm <= tlbRspPerm;
          rspMiss <= tlbRspMiss;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vsm_control.sv
module vsm_control
  import vsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        pathPass,
  input  logic        pathDirect,
  input  logic        tlbRspValid,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        tlbReqValid,
  output logic        rspValid,
  output logic        waiting
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_t;

  state_t stateQ;
  logic   accept;

  assign accept   = reqValid && (stateQ == ST_IDLE);
  assign reqReady = (stateQ == ST_IDLE);
  assign waiting  = (stateQ == ST_WAIT);

  always_comb begin
    strobe            = '0;
    strobe.loadPass   = accept && pathPass;
    strobe.loadDirect = accept && !pathPass && pathDirect;
    strobe.capture    = accept && !pathPass && !pathDirect;
    strobe.loadTlb    = waiting && tlbRspValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ      <= ST_IDLE;
      rspValid    <= 1'b0;
      tlbReqValid <= 1'b0;
    end else begin
      rspValid    <= strobe.loadPass | strobe.loadDirect | strobe.loadTlb;
      tlbReqValid <= strobe.capture;
      if (strobe.capture)      stateQ <= ST_WAIT;
      else if (strobe.loadTlb) stateQ <= ST_IDLE;
    end
  end

endmodule

// File: rtl/vaddr_segment_mapper.sv
module vaddr_segment_mapper
  import vsm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int PERM_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [1:0]                       reqKind,
  input  logic                             reqUser,
  input  logic [1:0]                       cfgEnable,
  input  logic [(1<<SEG_W)-1:0]            cfgSegMask,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  cfgBaseLo,
  input  logic [(SEG_W << (SEG_W-1))-1:0]  cfgBaseHi,
  input  logic [1:0]                       selIdle,
  output logic [1:0]                       mmuSel,
  output logic                             tlbReqValid,
  output logic [ADDR_W-1:0]                tlbReqAddr,
  output logic [1:0]                       tlbReqKind,
  output logic                             tlbReqUser,
  output logic                             tlbReqInstr,
  input  logic                             tlbRspValid,
  input  logic [ADDR_W-1:0]                tlbRspPhys,
  input  logic [PERM_W-1:0]                tlbRspPerm,
  input  logic                             tlbRspMiss,
  output logic                             rspValid,
  output logic [ADDR_W-1:0]                rspPhys,
  output logic [PERM_W-1:0]                rspPerm,
  output logic                             rspMiss
);
  ctrlStrobe_t strobe;
  logic        pathPass;
  logic        pathDirect;
  logic        waiting;
  logic [1:0]  routeSel;

  vsm_control uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .pathPass   (pathPass),
    .pathDirect (pathDirect),
    .tlbRspValid(tlbRspValid),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .tlbReqValid(tlbReqValid),
    .rspValid   (rspValid),
    .waiting    (waiting)
  );

  vsm_datapath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PERM_W(PERM_W)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .reqUser    (reqUser),
    .cfgEnable  (cfgEnable),
    .cfgSegMask (cfgSegMask),
    .cfgBaseLo  (cfgBaseLo),
    .cfgBaseHi  (cfgBaseHi),
    .tlbRspPhys (tlbRspPhys),
    .tlbRspPerm (tlbRspPerm),
    .tlbRspMiss (tlbRspMiss),
    .pathPass   (pathPass),
    .pathDirect (pathDirect),
    .tlbReqAddr (tlbReqAddr),
    .tlbReqKind (tlbReqKind),
    .tlbReqUser (tlbReqUser),
    .tlbReqInstr(tlbReqInstr),
    .routeSel   (routeSel),
    .rspPhys    (rspPhys),
    .rspPerm    (rspPerm),
    .rspMiss    (rspMiss)
  );

  // Routed selector while a lookup is outstanding, idle value otherwise
  assign mmuSel = waiting ? routeSel : selIdle;

endmodule

// File: rtl/vsm_checker.sv
module vsm_checker #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  parameter int PERM_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reqValid,
  input logic                  reqReady,
  input logic [ADDR_W-1:0]     reqAddr,
  input logic                  reqUser,
  input logic [1:0]            cfgEnable,
  input logic [(1<<SEG_W)-1:0] cfgSegMask,
  input logic [1:0]            selIdle,
  input logic [1:0]            mmuSel,
  input logic                  tlbReqValid,
  input logic [1:0]            tlbReqKind,
  input logic                  tlbReqInstr,
  input logic                  tlbRspValid,
  input logic [ADDR_W-1:0]     tlbRspPhys,
  input logic                  rspValid,
  input logic [ADDR_W-1:0]     rspPhys,
  input logic [PERM_W-1:0]     rspPerm,
  input logic                  rspMiss
);
  localparam int OFF_W = ADDR_W - SEG_W;
  localparam logic [PERM_W-1:0] PERM_ALL = {PERM_W{1'b1}};

  logic accepted;
  assign accepted = reqValid && reqReady;

  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && cfgEnable == 2'b00) |=>
      (rspValid && rspPhys == $past(reqAddr) && rspPerm == PERM_ALL && !rspMiss));

  a_r5_direct_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && cfgEnable != 2'b00 && !reqUser && cfgSegMask[reqAddr[ADDR_W-1 -: SEG_W]]) |=>
      (rspValid && !rspMiss && rspPerm == PERM_ALL &&
       rspPhys[OFF_W-1:0] == $past(reqAddr[OFF_W-1:0])));

  a_r7_lookup_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tlbReqValid |=> !tlbReqValid);

  a_r7_busy_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    tlbReqValid |-> !reqReady);

  a_r7_answer_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbRspValid && !reqReady) |=> (rspValid && rspPhys == $past(tlbRspPhys)));

  a_r8_instr_route: assert property (@(posedge clk) disable iff (!rst_n)
    tlbReqValid |-> (tlbReqInstr == (tlbReqKind == 2'b10) && mmuSel == (tlbReqInstr ? 2'd1 : 2'd2)));

  a_r8_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> mmuSel == selIdle);

  a_r9_no_result_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!reqReady && !tlbRspValid) |=> !rspValid && !tlbReqValid);

endmodule

bind vaddr_segment_mapper vsm_checker #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PERM_W(PERM_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .reqUser    (reqUser),
  .cfgEnable  (cfgEnable),
  .cfgSegMask (cfgSegMask),
  .selIdle    (selIdle),
  .mmuSel     (mmuSel),
  .tlbReqValid(tlbReqValid),
  .tlbReqKind (tlbReqKind),
  .tlbReqInstr(tlbReqInstr),
  .tlbRspValid(tlbRspValid),
  .tlbRspPhys (tlbRspPhys),
  .rspValid   (rspValid),
  .rspPhys    (rspPhys),
  .rspPerm    (rspPerm),
  .rspMiss    (rspMiss)
);

// File: tb/vaddr_segment_mapper_test.sv
`timescale 1ns/100ps
module vaddr_segment_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [1:0]  cfgEnable = '0;
  logic [15:0] cfgSegMask = '0;
  logic [31:0] cfgBaseLo = '0;
  logic [31:0] cfgBaseHi = '0;
  logic [1:0]  selIdle = 2'd0;
  logic [1:0]  mmuSel;
  logic        tlbReqValid;
  logic [31:0] tlbReqAddr;
  logic [1:0]  tlbReqKind;
  logic        tlbReqUser;
  logic        tlbReqInstr;
  logic        tlbRspValid = 1'b0;
  logic [31:0] tlbRspPhys = '0;
  logic [2:0]  tlbRspPerm = '0;
  logic        tlbRspMiss = 1'b0;
  logic        rspValid;
  logic [31:0] rspPhys;
  logic [2:0]  rspPerm;
  logic        rspMiss;

  always #2.5 clk = ~clk;

  vaddr_segment_mapper uut (.*);

  int total = 0;
  int bad = 0;
  string curTag = "R11";
  int tlbDelay = 1;
  int tlbCnt = -1;
  bit cmpOn = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic        mBusy, mRsp, mTlb;
  logic [31:0] mPhys, mAddr;
  logic [2:0]  mPerm;
  logic        mMiss, mUser;
  logic [1:0]  mKind;

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy <= 0; mRsp <= 0; mTlb <= 0; mPhys <= 0; mPerm <= 0; mMiss <= 0;
      mAddr <= 0; mKind <= 0; mUser <= 0;
    end else begin
      mRsp <= 0;
      mTlb <= 0;
      if (!mBusy) begin
        if (reqValid) begin
          int seg;
          logic [31:0] base;
          seg = int'(reqAddr[31:28]);
          if (cfgEnable == 2'b00) begin
            mRsp <= 1; mPhys <= reqAddr; mPerm <= 3'b111; mMiss <= 0;
          end else if (!reqUser && cfgSegMask[seg]) begin
            base = (seg < 8) ? cfgBaseLo : cfgBaseHi;
            mRsp <= 1; mPerm <= 3'b111; mMiss <= 0;
            mPhys <= {4'((base >> (4 * (seg % 8))) & 32'hF), reqAddr[27:0]};
          end else begin
            mBusy <= 1; mTlb <= 1; mAddr <= reqAddr; mKind <= reqKind; mUser <= reqUser;
          end
        end
      end else if (tlbRspValid) begin
        mBusy <= 0; mRsp <= 1; mPhys <= tlbRspPhys; mPerm <= tlbRspPerm; mMiss <= tlbRspMiss;
      end
    end
  end

  // Comparison one ns after every edge
  always @(posedge clk) begin
    #1;
    if (cmpOn) begin
      chk(rspValid == mRsp, curTag, "rspValid", 32'(rspValid), 32'(mRsp));
      if (mRsp) begin
        chk(rspPhys == mPhys, curTag, "rspPhys", rspPhys, mPhys);
        chk(rspPerm == mPerm, curTag, "rspPerm", 32'(rspPerm), 32'(mPerm));
        chk(rspMiss == mMiss, curTag, "rspMiss", 32'(rspMiss), 32'(mMiss));
      end
      chk(reqReady == !mBusy, curTag, "reqReady", 32'(reqReady), 32'(!mBusy));
      chk(tlbReqValid == mTlb, curTag, "tlbReqValid", 32'(tlbReqValid), 32'(mTlb));
      if (mTlb) begin
        chk(tlbReqAddr == mAddr, curTag, "tlbReqAddr", tlbReqAddr, mAddr);
        chk(tlbReqKind == mKind, curTag, "tlbReqKind", 32'(tlbReqKind), 32'(mKind));
        chk(tlbReqUser == mUser, curTag, "tlbReqUser", 32'(tlbReqUser), 32'(mUser));
        chk(tlbReqInstr == (mKind == 2'b10), "R8", "tlbReqInstr",
            32'(tlbReqInstr), 32'(mKind == 2'b10));
      end
      begin
        logic [1:0] expSel;
        expSel = mBusy ? ((mKind == 2'b10) ? 2'd1 : 2'd2) : selIdle;
        chk(mmuSel == expSel, "R8", "mmuSel", 32'(mmuSel), 32'(expSel));
      end
    end
  end

  // Lookup responder with programmable latency
  always @(negedge clk) begin
    tlbRspValid = 1'b0;
    if (!rst_n) begin
      tlbCnt = -1;
    end else begin
      if (tlbReqValid) tlbCnt = tlbDelay;
      if (tlbCnt == 0) begin
        tlbRspValid = 1'b1;
        tlbRspPhys  = {tlbReqAddr[31:12] ^ 20'hA5C3E, 12'h0F0};
        tlbRspPerm  = {1'b0, tlbReqAddr[13], 1'b1};
        tlbRspMiss  = tlbReqAddr[12];
        tlbCnt = -1;
      end else if (tlbCnt > 0) begin
        tlbCnt--;
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic u);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R11: reset state
    chk(rspValid == 0, "R11", "rspValid", 32'(rspValid), 0);
    chk(tlbReqValid == 0, "R11", "tlbReqValid", 32'(tlbReqValid), 0);
    chk(reqReady == 1, "R11", "reqReady", 32'(reqReady), 1);
    chk(mmuSel == selIdle, "R11", "mmuSel", 32'(mmuSel), 32'(selIdle));
    cmpOn = 1'b1;

    // R1: passthrough, other config present
    curTag = "R1";
    cfgEnable = 2'b00; cfgSegMask = 16'hFFFF;
    cfgBaseLo = 32'h9ABC_DEF1; cfgBaseHi = 32'h2468_ACE0;
    issue(32'h1234_5678, 2'b00, 1'b0);
    issue(32'hFFFF_FFFF, 2'b01, 1'b1);
    issue(32'h0000_0000, 2'b10, 1'b0);
    settle(2);

    // R2: each non-zero enable value gives translation
    curTag = "R2";
    cfgSegMask = 16'h0001;
    for (int e = 1; e < 4; e++) begin
      cfgEnable = 2'(e);
      issue(32'h0ABC_0123, 2'b00, 1'b0);
      issue(32'h3000_2000 + 32'(e), 2'b00, 1'b0);
      settle(4);
    end

    // R3/R4/R5: all segments in kernel mode, then user mode
    curTag = "R4";
    cfgEnable = 2'b10; cfgSegMask = 16'hA5C3;
    for (int s = 0; s < 16; s++) begin
      issue({4'(s), 28'h0F1_E2D3}, 2'b01, 1'b0);
      settle(4);
    end
    curTag = "R3";
    issue(32'h0000_4000, 2'b00, 1'b1);
    issue(32'hF000_6000, 2'b01, 1'b1);
    settle(4);
    curTag = "R5";
    cfgSegMask = 16'hFFFF;
    issue(32'h7ABC_DEF0, 2'b00, 1'b0);
    issue(32'h8000_0001, 2'b10, 1'b0);
    settle(2);

    // R6: back-to-back direct and passthrough requests
    curTag = "R6";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      reqValid = 1'b1; reqAddr = {4'(i * 3), 28'h555_0000 + 28'(i)}; reqKind = 2'b00; reqUser = 1'b0;
      cfgEnable = (i == 3) ? 2'b00 : 2'b11;
      @(negedge clk);
    end
    reqValid = 1'b0;
    settle(2);

    // R7/R8: paged path with varied latency and kinds
    curTag = "R7";
    cfgEnable = 2'b01; cfgSegMask = 16'h0000; selIdle = 2'd3;
    for (int d = 0; d < 6; d++) begin
      tlbDelay = d;
      issue(32'h4000_0000 + 32'(d << 12) + 32'(d << 13), 2'(d % 4), 1'(d % 2));
      settle(d + 3);
    end
    curTag = "R8";
    tlbDelay = 3;
    issue(32'h5555_3000, 2'b10, 1'b0);
    settle(6);
    issue(32'h6666_1000, 2'b11, 1'b1);
    settle(6);

    // R9: requests during a pending lookup are ignored
    curTag = "R9";
    tlbDelay = 5;
    issue(32'h7777_2000, 2'b01, 1'b1);
    cfgEnable = 2'b00;
    reqValid = 1'b1; reqAddr = 32'h1111_1111;
    settle(3);
    reqValid = 1'b0;
    settle(6);

    // R10: config changes while waiting do not alter the result
    curTag = "R10";
    cfgEnable = 2'b11; cfgSegMask = 16'h0000; tlbDelay = 4;
    issue(32'h9000_3000, 2'b00, 1'b0);
    cfgSegMask = 16'hFFFF; cfgEnable = 2'b00; cfgBaseHi = 32'hFFFF_FFFF;
    settle(8);
    cfgEnable = 2'b11; selIdle = 2'd1;
    issue(32'h9000_3000, 2'b00, 1'b0);
    settle(3);

    cmpOn = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule